// File: doc/BRIEF.md
# Two-Register Transfer Sequencer

This block is the hardwired controller for a small shared-bus datapath. The datapath has one working register B and two partner registers, Y and Z. A free-running slot counter splits time into frames of four clock cycles. In each frame the controller moves one word between B and one partner. Which partner, and in which direction, comes from a 2-bit opcode held in the instruction register.

The controller drives six active-low strobes. Three are bus enables, one per register; the register whose enable is low drives the shared bus. The other three are latch strobes; the register whose latch is low captures the bus. The source enable stays low for two slots. The destination latch is low only in the second of them, so the bus has settled before the capture happens.

The opcode is read at the edge that leaves the first slot and is held inside the block for the rest of the frame. A change to the instruction register later in the frame does not disturb a transfer already under way. Every strobe comes straight from a flip-flop, so decode hazards cannot cause a pulse when the counter changes state.

Top module: `hwXferCtl`

## Requirements
- R1: A synchronous active-high reset sets the slot count to 0 and drives all six strobes high on the same edge. This also holds when reset arrives in the middle of a frame.
- R2: Outside reset, the slot count advances by one on every clock and wraps from 3 to 0.
- R3: In slots 0 and 3 all six strobes are high.
- R4: Opcode bit 0 chooses the partner (0 = Y, 1 = Z). Opcode bit 1 chooses the direction (0 = B is loaded from the partner, 1 = B is stored into the partner). Opcode 0 uses enable Y with latch B. Opcode 1 uses enable Z with latch B. Opcode 2 uses enable B with latch Y. Opcode 3 uses enable B with latch Z. The transferred word lands in the destination register by the end of the frame.
- R5: The enable that belongs to the opcode is low in slots 1 and 2 and high in every other slot.
- R6: The latch that belongs to the opcode is low in slot 2 only. A low latch is always paired with a low enable.
- R7: At most one enable and at most one latch are low in any cycle. Every strobe that does not belong to the opcode stays high.
- R8: The opcode is sampled at the edge that leaves slot 0. Changes to it in slots 1 to 3 have no effect on the strobes of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| irOp | input | 2 | Opcode from the instruction register |
| slot | output | 2 | Current time slot, 0 to 3 |
| enYn | output | 1 | Y drives the bus, active low |
| enZn | output | 1 | Z drives the bus, active low |
| enBn | output | 1 | B drives the bus, active low |
| ldBn | output | 1 | B captures the bus, active low |
| ldYn | output | 1 | Y captures the bus, active low |
| ldZn | output | 1 | Z captures the bus, active low |

## Verification
The assertions check the following on every cycle:
- the slot count steps by one;
- all strobes are quiet in slots 0 and 3;
- enables are low only inside the two-slot window, and latches only in its second slot;
- no two enables and no two latches are low together;
- each low latch has a low enable beside it;
- the held opcode does not change after slot 0.

Only the bench scenarios can show the rest:
- each opcode selects the right strobe pair and moves the correct word between the modelled registers;
- an opcode change in the middle of a frame is ignored;
- reset in the middle of a frame returns the block to a clean slot 0, and the next frame picks up the new opcode.

// File: rtl/ctlPkg.sv
package ctlPkg;

  // Decoded opcode: each opcode bit as a true line and a complement line
  typedef struct packed {
    logic isY;
    logic isZ;
    logic isLoad;
    logic isSave;
  } opLines_t;

  // Active-low strobes to the datapath
  typedef struct packed {
    logic enY;
    logic enZ;
    logic enB;
    logic ldB;
    logic ldY;
    logic ldZ;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '1;

endpackage

// File: rtl/slotTimer.sv
module slotTimer #(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] nextSlot,
  output logic              frameStart
);

  assign nextSlot   = slot + 1'b1;
  assign frameStart = (slot == '0);

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= nextSlot;
  end

  // The count steps by one and wraps at the top
  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (slot == $past(slot) + 1'b1));

endmodule

// File: rtl/opDecoder.sv
module opDecoder
  import ctlPkg::*;
#(
  parameter int OP_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] irOp,
  input  logic            frameStart,
  output opLines_t        lines
);

  localparam int SEL_BIT = 0;
  localparam int DIR_BIT = 1;

  logic [OP_W-1:0] opHeld;
  logic [OP_W-1:0] opEff;

  // In slot 0 the live opcode is used; after that the held copy
  assign opEff = frameStart ? irOp : opHeld;

  always_ff @(posedge clk) begin
    if (rst)             opHeld <= '0;
    else if (frameStart) opHeld <= irOp;
  end

  always_comb begin
    lines.isZ    =  opEff[SEL_BIT];
    lines.isY    = ~opEff[SEL_BIT];
    lines.isSave =  opEff[DIR_BIT];
    lines.isLoad = ~opEff[DIR_BIT];
  end

  // The held opcode is frozen for the rest of the frame
  p_hold_op_r8: assert property (@(posedge clk) disable iff (rst)
    !frameStart |=> $stable(opHeld));

endmodule

// File: rtl/strobeGen.sv
module strobeGen
  import ctlPkg::*;
#(
  parameter int SLOT_W    = 2,
  parameter int ENA_FIRST = 1,
  parameter int LAT_SLOT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] nextSlot,
  input  opLines_t          lines,
  output strobes_t          strb
);

  localparam logic [SLOT_W-1:0] WIN_LO = SLOT_W'(ENA_FIRST);
  localparam logic [SLOT_W-1:0] WIN_HI = SLOT_W'(LAT_SLOT);

  logic     enWin;
  logic     latWin;
  strobes_t strbNext;

  // Window tests use the slot about to begin, so the flops line up with slot
  assign enWin  = (nextSlot >= WIN_LO) && (nextSlot <= WIN_HI);
  assign latWin = (nextSlot == WIN_HI);

  always_comb begin
    strbNext.enY = ~(enWin  & lines.isLoad & lines.isY);
    strbNext.enZ = ~(enWin  & lines.isLoad & lines.isZ);
    strbNext.enB = ~(enWin  & lines.isSave);
    strbNext.ldB = ~(latWin & lines.isLoad);
    strbNext.ldY = ~(latWin & lines.isSave & lines.isY);
    strbNext.ldZ = ~(latWin & lines.isSave & lines.isZ);
  end

  always_ff @(posedge clk) begin
    if (rst) strb <= STROBES_IDLE;
    else     strb <= strbNext;
  end

  logic anyEnLow;
  logic anyLdLow;
  assign anyEnLow = ~(strb.enY & strb.enZ & strb.enB);
  assign anyLdLow = ~(strb.ldB & strb.ldY & strb.ldZ);

  p_quiet_slots_r3: assert property (@(posedge clk) disable iff (rst)
    !((slot >= WIN_LO) && (slot <= WIN_HI)) |-> (strb == STROBES_IDLE));

  p_enable_window_r5: assert property (@(posedge clk) disable iff (rst)
    anyEnLow |-> ((slot >= WIN_LO) && (slot <= WIN_HI)));

  p_latch_window_r6: assert property (@(posedge clk) disable iff (rst)
    anyLdLow |-> (slot == WIN_HI));

  p_latch_paired_r6: assert property (@(posedge clk) disable iff (rst)
    anyLdLow |-> anyEnLow);

  p_one_enable_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(~{strb.enY, strb.enZ, strb.enB}) <= 1);

  p_one_latch_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(~{strb.ldB, strb.ldY, strb.ldZ}) <= 1);

endmodule

// File: rtl/hwXferCtl.sv
module hwXferCtl
  import ctlPkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int OP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   irOp,
  output logic [SLOT_W-1:0] slot,
  output logic              enYn,
  output logic              enZn,
  output logic              enBn,
  output logic              ldBn,
  output logic              ldYn,
  output logic              ldZn
);

  logic [SLOT_W-1:0] nextSlot;
  logic              frameStart;
  opLines_t          lines;
  strobes_t          strb;

  slotTimer #(.SLOT_W(SLOT_W)) uTimer (
    .clk(clk), .rst(rst), .slot(slot), .nextSlot(nextSlot),
    .frameStart(frameStart)
  );

  opDecoder #(.OP_W(OP_W)) uDecode (
    .clk(clk), .rst(rst), .irOp(irOp), .frameStart(frameStart),
    .lines(lines)
  );

  strobeGen #(.SLOT_W(SLOT_W), .ENA_FIRST(1), .LAT_SLOT(2)) uStrobe (
    .clk(clk), .rst(rst), .slot(slot), .nextSlot(nextSlot),
    .lines(lines), .strb(strb)
  );

  assign enYn = strb.enY;
  assign enZn = strb.enZ;
  assign enBn = strb.enB;
  assign ldBn = strb.ldB;
  assign ldYn = strb.ldY;
  assign ldZn = strb.ldZ;

  // Reset always leaves every strobe released (R1)
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (strb == STROBES_IDLE && slot == '0));

endmodule

// File: tb/sim_hwXferCtl.sv
module sim_hwXferCtl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] irOp = 2'd0;
  logic [1:0] slot;
  logic       enYn, enZn, enBn, ldBn, ldYn, ldZn;

  always #2 clk = ~clk;

  hwXferCtl u0 (
    .clk(clk), .rst(rst), .irOp(irOp), .slot(slot),
    .enYn(enYn), .enZn(enZn), .enBn(enBn),
    .ldBn(ldBn), .ldYn(ldYn), .ldZn(ldZn)
  );

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  int         eSlot = 0;
  logic [1:0] eOp = 2'd0;
  logic [7:0] regY, regZ, regB, busVal;

  // {op, Y, Z, B, expected Y, expected Z, expected B}
  localparam logic [49:0] VECS [6] = '{
    {2'd0, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h11},
    {2'd1, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h22},
    {2'd2, 8'h11, 8'h22, 8'h33, 8'h33, 8'h22, 8'h33},
    {2'd3, 8'h11, 8'h22, 8'h33, 8'h11, 8'h33, 8'h33},
    {2'd3, 8'hF0, 8'h0F, 8'hAA, 8'hF0, 8'hAA, 8'hAA},
    {2'd1, 8'h00, 8'hC3, 8'hFF, 8'h00, 8'hC3, 8'hC3}
  };

  // Expected {enY,enZ,enB,ldB,ldY,ldZ} for a slot and frame opcode
  function automatic logic [5:0] expStrb(int s, logic [1:0] op);
    logic enW, ltW, z, sv;
    enW = (s == 1) || (s == 2);
    ltW = (s == 2);
    z   = op[0];
    sv  = op[1];
    return {~(enW & ~sv & ~z), ~(enW & ~sv & z), ~(enW & sv),
            ~(ltW & ~sv), ~(ltW & sv & ~z), ~(ltW & sv & z)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // One clock: update expectations, check slot and strobes, run the bus model
  task automatic tick();
    logic       rstAtEdge;
    logic [1:0] opAtEdge;
    rstAtEdge = rst;
    opAtEdge  = irOp;
    @(posedge clk);
    #1;
    if (rstAtEdge) eSlot = 0;
    else begin
      if (eSlot == 0) eOp = opAtEdge;
      eSlot = (eSlot + 1) % 4;
    end
    check("R2 R3 R4 R5 R6 R7 slot+strobes",
          {24'd0, slot, enYn, enZn, enBn, ldBn, ldYn, ldZn},
          {24'd0, 2'(eSlot), expStrb(eSlot, eOp)});
    busVal = !enYn ? regY : !enZn ? regZ : !enBn ? regB : 8'hxx;
    if (!ldBn) regB = busVal;
    if (!ldYn) regY = busVal;
    if (!ldZn) regZ = busVal;
  endtask

  initial begin
    regY = 8'h00; regZ = 8'h00; regB = 8'h00;
    rst = 1'b1;
    repeat (3) tick();
    check("R1 reset slot+strobes",
          {24'd0, slot, enYn, enZn, enBn, ldBn, ldYn, ldZn}, {24'd0, 2'd0, 6'h3F});
    rst = 1'b0;

    // Table walk: one full frame per opcode vector (R4)
    for (int i = 0; i < 6; i++) begin
      while (eSlot != 0) tick();
      {irOp, regY, regZ, regB} = VECS[i][49:24];
      repeat (4) tick();
      check("R4 reg Y", {24'd0, regY}, {24'd0, VECS[i][23:16]});
      check("R4 reg Z", {24'd0, regZ}, {24'd0, VECS[i][15:8]});
      check("R4 reg B", {24'd0, regB}, {24'd0, VECS[i][7:0]});
    end

    // R8: opcode changes after slot 0 must not affect the frame
    while (eSlot != 0) tick();
    irOp = 2'd0; regY = 8'h5A; regZ = 8'hA5; regB = 8'h00;
    tick();
    irOp = 2'd3;
    repeat (3) tick();
    check("R8 B loaded from Y despite change", {24'd0, regB}, {24'd0, 8'h5A});
    check("R8 Z untouched", {24'd0, regZ}, {24'd0, 8'hA5});

    // R1: reset in mid-frame, then a clean restart with the new opcode
    while (eSlot != 0) tick();
    irOp = 2'd2;
    repeat (2) tick();
    rst = 1'b1;
    tick();
    check("R1 mid-frame reset",
          {24'd0, slot, enYn, enZn, enBn, ldBn, ldYn, ldZn}, {24'd0, 2'd0, 6'h3F});
    rst = 1'b0;
    irOp = 2'd1;
    repeat (8) tick();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule